// File: doc/BRIEF.md
# Vectored Dual-Bank Interrupt Controller

This block gathers up to 32 interrupt sources and delivers them on two independent request lines: a normal line and a fast line. Each source first passes through a shared conditioning stage. That stage sets the source's polarity and chooses whether it follows its input level or holds a latched request. The block then routes the source to exactly one of two banks. Each bank masks, filters by a priority limit and arbitrates on its own. Software sees a bank as a set of registers that report the pending vector, the unmasked conditioned sources, the enable mask and the number of the source to service. Reading the bank's acknowledge word returns that number and drops the held request of that source.

Software talks to the block over a plain 32-bit register bus with an address, a write strobe, a read strobe and write data. There is no data stream here, so the bus has no valid/ready pair and no back-pressure. Every access completes in one cycle. Read data is registered and appears on `bus_rdata_o` in the cycle after the read strobe. The request lines are combinational from the sources and the configuration registers.

Top module: `vec_intc`

## Requirements
- R1: After reset both enable masks are 0, the polarity word is all ones, the sticky word is 0, every source priority is 0, both bank limits are 0xF and both request lines are low. Read data appears on `bus_rdata_o` one cycle after the read strobe.
- R2: In a bank, a 1 written to the enable word (offset 0x08) sets that enable bit and a 1 written to the disable word (offset 0x0C) clears it. Zero bits in either word have no effect. Reading the enable word returns the mask.
- R3: A polarity bit of 1 (shared word 0x200) passes its source through unchanged, and a bit of 0 inverts it. The raw word (bank offset 0x04) returns the conditioned sources before any enable masking, and it reads the same in both banks.
- R4: A sticky bit of 0 (shared word 0x204) makes the source follow its conditioned level. A bit of 1 holds a seen request until that source is acknowledged.
- R5: A source enabled in the fast bank mask belongs to the fast bank only. The normal bank takes sources enabled in its own mask and not in the fast mask. The status word (offset 0x00) shows the qualifying pending sources of its bank, and each request line is high exactly when its bank's status is non-zero.
- R6: Within a bank the qualifying source with the smallest priority value wins, and ties go to the lowest source number. The current word (offset 0x20) returns the winner's number, or 0 when nothing qualifies.
- R7: A source qualifies in a bank only if its 4-bit priority (word 0x300 + 4*n for source n) is less than or equal to that bank's limit (offset 0x2C).
- R8: A read of the acknowledge word (offset 0x28) returns the current winner's number and clears the held request of that source. A level-following source stays pending while its input stays active. With nothing pending the read returns 0 and changes nothing.
- R9: Writes to the status, raw, current and acknowledge words, and writes to any address with bits above bit 9 set, change no state. Reads of the disable word and of unmapped addresses return 0.
- R10: The normal bank occupies 0x000-0x0FF, the fast bank 0x100-0x1FF, the shared polarity and sticky words 0x200 and 0x204, and the priority words 0x300-0x37C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source inputs, one bit per source |
| bus_addr_i | input | 12 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Normal bank request line |
| fiq_o | output | 1 | Fast bank request line |

## Verification
The sources are driven in patterns that separate each effect. Three sources with two distinct priority values and one tie show whether the priority value or the source number decides the winner. The same set is then filtered by a limit just below and just at the tie value, which shows whether the limit comparison is inclusive. A short pulse on sticky sources followed by repeated acknowledges shows the held requests draining in priority order. A level source held high shows that an acknowledge does not clear a live level. Overlapping normal and fast enables on one source show that the fast bank takes exclusive ownership of it.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

  localparam int unsigned DW    = 32;
  localparam int unsigned NBANK = 2;

  // word offsets inside one bank page
  localparam logic [7:0] W_STAT = 8'h00;
  localparam logic [7:0] W_RAW  = 8'h04;
  localparam logic [7:0] W_EN   = 8'h08;
  localparam logic [7:0] W_DIS  = 8'h0C;
  localparam logic [7:0] W_CUR  = 8'h20;
  localparam logic [7:0] W_ACK  = 8'h28;
  localparam logic [7:0] W_LIM  = 8'h2C;

  // word offsets inside the shared page
  localparam logic [7:0] W_POL  = 8'h00;
  localparam logic [7:0] W_STK  = 8'h04;

  // page selector, address bits [9:8]
  localparam logic [1:0] PG_NORM = 2'd0;
  localparam logic [1:0] PG_FAST = 2'd1;
  localparam logic [1:0] PG_SHR  = 2'd2;
  localparam logic [1:0] PG_PRI  = 2'd3;

endpackage

// File: rtl/vec_intc_src_cond.sv
module vec_intc_src_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic pass_i,
  input  logic sticky_i,
  input  logic clr_i,
  output logic pend_o
);

  logic lvl;
  logic hold_q;

  assign lvl = pass_i ? src_i : !src_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (clr_i || !sticky_i) begin
      hold_q <= 1'b0;
    end else if (lvl) begin
      hold_q <= 1'b1;
    end
  end

  assign pend_o = sticky_i ? hold_q : lvl;

  // R8: an acknowledge drops a held request for one cycle at least
  a_r8_ack_drops_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && sticky_i) |=> (!pend_o || !sticky_i));

endmodule

// File: rtl/vec_intc_arb.sv
module vec_intc_arb #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 4,
  parameter int ID_W   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        req_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  output logic                   hit_o,
  output logic [ID_W-1:0]        id_o
);

  // binary reduction tree; NSRC must be a power of two
  localparam int NODES = 2*NSRC - 1;

  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [ID_W-1:0]   ni [NODES];

  for (genvar i = 0; i < NSRC; i++) begin : g_leaf
    assign nv[NSRC-1+i] = req_i[i];
    assign np[NSRC-1+i] = prio_i[i*PRIO_W +: PRIO_W];
    assign ni[NSRC-1+i] = ID_W'(i);
  end

  for (genvar k = 0; k < NSRC-1; k++) begin : g_node
    logic take_r;
    // left child holds the lower source numbers, so it wins ties
    assign take_r = nv[2*k+2] && (!nv[2*k+1] || (np[2*k+2] < np[2*k+1]));
    assign nv[k]  = nv[2*k+1] || nv[2*k+2];
    assign np[k]  = take_r ? np[2*k+2] : np[2*k+1];
    assign ni[k]  = take_r ? ni[2*k+2] : ni[2*k+1];
  end

  assign hit_o = nv[0];
  assign id_o  = ni[0];

endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam int ID_W = $clog2(NSRC);

  // configuration state
  logic [NSRC-1:0]   en_q  [NBANK];
  logic [PRIO_W-1:0] lim_q [NBANK];
  logic [NSRC-1:0]   pol_q;
  logic [NSRC-1:0]   stk_q;
  logic [PRIO_W-1:0] pri_q [NSRC];
  logic [DW-1:0]     rdata_q;

  // address decode
  logic [1:0]   page;
  logic [7:0]   low;
  logic         in_map;
  logic [ID_W-1:0] pri_idx;
  logic         pri_ok;

  assign page    = bus_addr_i[9:8];
  assign low     = bus_addr_i[7:0];
  assign in_map  = (bus_addr_i[ADDR_W-1:10] == '0);
  assign pri_idx = low[ID_W+1:2];
  assign pri_ok  = ((low[7:2] >> ID_W) == '0) && (low[1:0] == 2'b00);

  // source conditioning and bank qualification
  logic [NSRC-1:0]        pend;
  logic [NSRC-1:0]        clr;
  logic [NSRC*PRIO_W-1:0] pri_flat;
  logic [NSRC-1:0]        mask [NBANK];
  logic [NSRC-1:0]        qual [NBANK];
  logic [NBANK-1:0]       hit;
  logic [ID_W-1:0]        win_id [NBANK];
  logic [ID_W-1:0]        cur    [NBANK];
  logic [NBANK-1:0]       ack_rd;
  logic [NBANK-1:0]       en_wr;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    vec_intc_src_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_i[i]),
      .pass_i   (pol_q[i]),
      .sticky_i (stk_q[i]),
      .clr_i    (clr[i]),
      .pend_o   (pend[i])
    );
    assign pri_flat[i*PRIO_W +: PRIO_W] = pri_q[i];
  end

  always_comb begin
    // fast bank owns any source in its mask
    mask[0] = en_q[0] & ~en_q[1];
    mask[1] = en_q[1];
    for (int b = 0; b < NBANK; b++) begin
      for (int i = 0; i < NSRC; i++) begin
        qual[b][i] = pend[i] && mask[b][i] && (pri_q[i] <= lim_q[b]);
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    vec_intc_arb #(
      .NSRC   (NSRC),
      .PRIO_W (PRIO_W),
      .ID_W   (ID_W)
    ) u_arb (
      .req_i  (qual[b]),
      .prio_i (pri_flat),
      .hit_o  (hit[b]),
      .id_o   (win_id[b])
    );
    assign cur[b]    = hit[b] ? win_id[b] : '0;
    assign ack_rd[b] = bus_rd_i && in_map && (page == 2'(b)) && (low == W_ACK);
    assign en_wr[b]  = bus_wr_i && in_map && (page == 2'(b)) && (low == W_EN);

    // R6: a reported winner is a qualifying source of its bank
    a_r6_winner_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
      hit[b] |-> qual[b][win_id[b]]);

    // R7: a reported winner never exceeds the bank limit
    a_r7_winner_under_limit: assert property (@(posedge clk) disable iff (!rst_n)
      hit[b] |-> (pri_q[win_id[b]] <= lim_q[b]));

    // R2: ones written to the enable word are set afterwards
    a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr[b] |=> ((en_q[b] & $past(bus_wdata_i[NSRC-1:0])) == $past(bus_wdata_i[NSRC-1:0])));
  end

  // acknowledge clears the held request of the bank winner
  always_comb begin
    clr = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (ack_rd[b] && hit[b]) clr[win_id[b]] = 1'b1;
    end
  end

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        en_q[b]  <= '0;
        lim_q[b] <= '1;
      end
      pol_q <= '1;
      stk_q <= '0;
      for (int i = 0; i < NSRC; i++) pri_q[i] <= '0;
    end else if (bus_wr_i && in_map) begin
      case (page)
        PG_NORM, PG_FAST: begin
          case (low)
            W_EN:    en_q[page[0]]  <= en_q[page[0]] | bus_wdata_i[NSRC-1:0];
            W_DIS:   en_q[page[0]]  <= en_q[page[0]] & ~bus_wdata_i[NSRC-1:0];
            W_LIM:   lim_q[page[0]] <= bus_wdata_i[PRIO_W-1:0];
            default: ;
          endcase
        end
        PG_SHR: begin
          case (low)
            W_POL:   pol_q <= bus_wdata_i[NSRC-1:0];
            W_STK:   stk_q <= bus_wdata_i[NSRC-1:0];
            default: ;
          endcase
        end
        default: begin
          if (pri_ok) pri_q[pri_idx] <= bus_wdata_i[PRIO_W-1:0];
        end
      endcase
    end
  end

  // read multiplexer
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (in_map) begin
      case (page)
        PG_NORM, PG_FAST: begin
          case (low)
            W_STAT:  rd_mux = DW'(qual[page[0]]);
            W_RAW:   rd_mux = DW'(pend);
            W_EN:    rd_mux = DW'(en_q[page[0]]);
            W_CUR,
            W_ACK:   rd_mux = DW'(cur[page[0]]);
            W_LIM:   rd_mux = DW'(lim_q[page[0]]);
            default: rd_mux = '0;
          endcase
        end
        PG_SHR: begin
          case (low)
            W_POL:   rd_mux = DW'(pol_q);
            W_STK:   rd_mux = DW'(stk_q);
            default: rd_mux = '0;
          endcase
        end
        default: begin
          if (pri_ok) rd_mux = DW'(pri_q[pri_idx]);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = |qual[0];
  assign fiq_o       = |qual[1];

  // R5: no source is ever pending in both banks
  a_r5_banks_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (qual[0] & qual[1]) == '0);

endmodule

// File: tb/vec_intc_tb_top.sv
module vec_intc_tb_top;

  localparam int CLK_P  = 10;
  localparam int WD_CYC = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_line;
  logic        fiq_line;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vec_intc dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq_line),
    .fiq_o       (fiq_line)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    reg_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq line", {31'b0, irq_line}, 32'h0);
    chk("R1 fiq line", {31'b0, fiq_line}, 32'h0);
    rd_chk("R1 normal enable", 12'h008, 32'h0);
    rd_chk("R1 fast enable",   12'h108, 32'h0);
    rd_chk("R1 polarity",      12'h200, 32'hFFFF_FFFF);
    rd_chk("R1 sticky",        12'h204, 32'h0);
    rd_chk("R1 prio 0",        12'h300, 32'h0);
    rd_chk("R1 prio 31",       12'h37C, 32'h0);
    rd_chk("R1 normal limit",  12'h02C, 32'hF);
    rd_chk("R1 fast limit",    12'h12C, 32'hF);
  endtask

  task automatic t_enable;
    reg_wr(12'h008, 32'h0000_00F0);
    reg_wr(12'h008, 32'h0000_0F00);
    rd_chk("R2 set accumulates", 12'h008, 32'h0000_0FF0);
    reg_wr(12'h00C, 32'h0000_0030);
    rd_chk("R2 clear bits", 12'h008, 32'h0000_0FC0);
    reg_wr(12'h00C, 32'h0);
    rd_chk("R2 zero clear no effect", 12'h008, 32'h0000_0FC0);
    reg_wr(12'h008, 32'h0);
    rd_chk("R2 zero set no effect", 12'h008, 32'h0000_0FC0);
    rd_chk("R2 fast mask untouched", 12'h108, 32'h0);
    reg_wr(12'h00C, 32'hFFFF_FFFF);
    rd_chk("R2 clear all", 12'h008, 32'h0);
  endtask

  task automatic t_polarity;
    set_src(32'h0000_0005);
    rd_chk("R3 raw normal page", 12'h004, 32'h0000_0005);
    rd_chk("R3 raw fast page",   12'h104, 32'h0000_0005);
    reg_wr(12'h200, 32'hFFFF_FFFE);
    rd_chk("R3 bit0 inverted high", 12'h004, 32'h0000_0004);
    set_src(32'h0);
    rd_chk("R3 bit0 inverted low", 12'h004, 32'h0000_0001);
    chk("R3 raw not gated by enable", {31'b0, irq_line}, 32'h0);
    reg_wr(12'h200, 32'hFFFF_FFFF);
    rd_chk("R3 polarity restored", 12'h004, 32'h0);
  endtask

  task automatic t_sticky;
    reg_wr(12'h204, 32'h0000_0008);
    reg_wr(12'h008, 32'h0000_0018);
    set_src(32'h0000_0018);
    rd_chk("R4 both seen", 12'h004, 32'h0000_0018);
    set_src(32'h0);
    rd_chk("R4 sticky holds, level drops", 12'h004, 32'h0000_0008);
    rd_chk("R4 status held", 12'h000, 32'h0000_0008);
    @(negedge clk);
    chk("R4 line held", {31'b0, irq_line}, 32'h1);
    rd_chk("R8 ack returns 3", 12'h028, 32'd3);
    rd_chk("R4 released by ack", 12'h004, 32'h0);
    @(negedge clk);
    chk("R4 line released", {31'b0, irq_line}, 32'h0);
    reg_wr(12'h00C, 32'hFFFF_FFFF);
    reg_wr(12'h204, 32'h0);
  endtask

  task automatic t_routing;
    reg_wr(12'h008, 32'h0000_0006);
    reg_wr(12'h108, 32'h0000_0004);
    set_src(32'h0000_0006);
    rd_chk("R5 normal status", 12'h000, 32'h0000_0002);
    rd_chk("R5 fast status",   12'h100, 32'h0000_0004);
    @(negedge clk);
    chk("R5 irq line", {31'b0, irq_line}, 32'h1);
    chk("R5 fiq line", {31'b0, fiq_line}, 32'h1);
    set_src(32'h0000_0004);
    chk("R5 irq idle when only fast source", {31'b0, irq_line}, 32'h0);
    chk("R5 fiq still set", {31'b0, fiq_line}, 32'h1);
    rd_chk("R5 normal status empty", 12'h000, 32'h0);
    set_src(32'h0);
    reg_wr(12'h00C, 32'hFFFF_FFFF);
    reg_wr(12'h10C, 32'hFFFF_FFFF);
  endtask

  task automatic t_arbitrate;
    reg_wr(12'h314, 32'd7);
    reg_wr(12'h324, 32'd2);
    reg_wr(12'h350, 32'd2);
    rd_chk("R10 prio word 20", 12'h350, 32'd2);
    reg_wr(12'h008, 32'hFFFF_FFFF);
    set_src(32'h0010_0220);
    rd_chk("R6 tie goes to lower number", 12'h020, 32'd9);
    set_src(32'h0010_0020);
    rd_chk("R6 lower value wins", 12'h020, 32'd20);
    set_src(32'h0000_0020);
    rd_chk("R6 single source", 12'h020, 32'd5);
    set_src(32'h0);
    rd_chk("R6 none gives 0", 12'h020, 32'd0);
    reg_wr(12'h108, 32'h0010_0000);
    set_src(32'h0010_0220);
    rd_chk("R6 fast bank winner", 12'h120, 32'd20);
    rd_chk("R6 normal bank without 20", 12'h020, 32'd9);
    set_src(32'h0);
    reg_wr(12'h10C, 32'hFFFF_FFFF);
  endtask

  task automatic t_limit;
    set_src(32'h0000_0220);
    reg_wr(12'h02C, 32'd1);
    rd_chk("R7 all above limit", 12'h000, 32'h0);
    rd_chk("R7 current empty", 12'h020, 32'd0);
    @(negedge clk);
    chk("R7 line low", {31'b0, irq_line}, 32'h0);
    reg_wr(12'h02C, 32'd2);
    rd_chk("R7 limit inclusive", 12'h000, 32'h0000_0200);
    rd_chk("R7 current at limit", 12'h020, 32'd9);
    rd_chk("R7 fast limit untouched", 12'h12C, 32'hF);
    reg_wr(12'h02C, 32'hF);
    rd_chk("R7 all pass", 12'h000, 32'h0000_0220);
    set_src(32'h0);
  endtask

  task automatic t_ack;
    reg_wr(12'h204, 32'h0010_0220);
    set_src(32'h0010_0220);
    set_src(32'h0);
    rd_chk("R8 held set", 12'h000, 32'h0010_0220);
    rd_chk("R8 first ack", 12'h028, 32'd9);
    rd_chk("R8 second ack", 12'h028, 32'd20);
    rd_chk("R8 third ack", 12'h028, 32'd5);
    rd_chk("R8 empty ack", 12'h028, 32'd0);
    rd_chk("R8 drained", 12'h000, 32'h0);
    reg_wr(12'h204, 32'h0);
    set_src(32'h0000_0200);
    rd_chk("R8 level ack", 12'h028, 32'd9);
    rd_chk("R8 level stays pending", 12'h000, 32'h0000_0200);
    set_src(32'h0);
  endtask

  task automatic t_ignored;
    reg_wr(12'h000, 32'hFFFF_FFFF);
    reg_wr(12'h004, 32'hFFFF_FFFF);
    reg_wr(12'h020, 32'hFFFF_FFFF);
    reg_wr(12'h028, 32'hFFFF_FFFF);
    rd_chk("R9 status unchanged", 12'h000, 32'h0);
    rd_chk("R9 raw unchanged", 12'h004, 32'h0);
    rd_chk("R9 enable unchanged", 12'h008, 32'hFFFF_FFFF);
    rd_chk("R9 disable reads 0", 12'h00C, 32'h0);
    reg_wr(12'h600, 32'h0);
    rd_chk("R9 out of map write ignored", 12'h200, 32'hFFFF_FFFF);
    rd_chk("R9 out of map read 0", 12'h600, 32'h0);
    rd_chk("R9 unmapped page word 0", 12'h010, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_polarity();
    t_sticky();
    t_routing();
    t_arbitrate();
    t_limit();
    t_ack();
    t_ignored();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=%0d exp=finished", WD_CYC);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule